// File: doc/BRIEF.md
# AXI INCR Burst Chopper

This block takes one AXI read or write address request and turns it into a series of sub-requests for a fabric whose beats are 128 bits (16 bytes) wide. Each sub-request carries its own address, length and transfer size. The block decides three things for every request:

- whether the request is modifiable or must keep its original beats;
- which byte boundary no sub-request may cross;
- whether the request may be split at all.

A small tracker counts the pieces of each write. It merges their write responses into one response for the originator.

The request side, the sub-request side and both response sides are valid/ready streams. A request is accepted only when the block is idle and the tracker has room. While the pieces of one request are being issued, `req_ready` stays low. A sub-request whose `sub_valid` is high holds all of its fields until `sub_ready` is seen. A merged response holds until `bout_ready` is seen. While a merged response waits, no new piece response is taken. The interleave settings and the DDR-target flag are plain inputs, sampled with the request.

Top module: `axi_burst_chopper`

## Requirements
- R1: `req_ready` is low whenever a sub-request is pending or the write tracker is full. While `sub_valid` is high and `sub_ready` is low, every sub-request field stays unchanged.
- R2: A modifiable INCR request that is not exclusive is issued with size 4 (16 bytes per beat). Its pieces cover exactly the bytes from the start address to the end of the original burst.
- R3: The chop span is 256 bytes, except for a DDR request with interleaving enabled. That request uses 2^g bytes, where g is `ilv_gran_lg` clamped to the range 4..8.
- R4: No INCR piece crosses a multiple of the chop span. Only the first piece may start unaligned. Each following piece starts at the next span boundary, and `sub_last` is high only on the final piece.
- R5: A non-modifiable INCR request of size 4 or less to a non-DDR target keeps its size (narrow transfer), and `size_irq` stays low.
- R6: A non-modifiable, non-exclusive INCR request narrower than size 4 to a DDR target is issued with size 4 and raises `size_irq`.
- R7: A non-modifiable request wider than size 4 is issued with size 4 and raises `size_irq`. `size_irq` is a one-cycle pulse in the cycle after the request is accepted.
- R8: An exclusive request (`req_lock`=1, INCR) is never split, and its lock and cache-modifiable bits pass unchanged. With a DDR target and length 0, it keeps its size if that size is 4 or less. With a DDR target and length above 0, it goes to size 4 without an interrupt. Otherwise it follows the non-modifiable rules.
- R9: A FIXED burst (burst code 0) is issued as one piece at the same address, with size min(size,4). When that size is reduced, the length becomes (len+1)*2^(size-4)-1 and `size_irq` is raised.
- R10: Burst codes 2 and 3 pass through as one unchanged piece, with no interrupt.
- R11: Every write request gives exactly one merged response, after the responses of all its pieces. Its code is the numerically largest piece code (0 OKAY, 1 EXOKAY, 2 SLVERR, 3 DECERR). Read requests give none.
- R12: While `bout_valid` is high, `bin_ready` is low. While `bout_ready` is low, `bout_valid` and `bout_code` hold.
- R13: After reset, `req_ready` is high and `sub_valid`, `bout_valid` and `size_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write request, 0 = read |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Beats minus one |
| req_size | input | 3 | log2 bytes per beat |
| req_burst | input | 2 | 0 FIXED, 1 INCR, 2/3 passed through |
| req_cache_mod | input | 1 | Cache modifiable bit |
| req_lock | input | 1 | Exclusive access |
| req_ddr | input | 1 | Request targets DDR |
| ilv_enable | input | 1 | DDR interleaving enabled |
| ilv_gran_lg | input | 4 | log2 of interleave granularity in bytes |
| sub_valid | output | 1 | Sub-request valid |
| sub_ready | input | 1 | Sub-request taken |
| sub_addr | output | ADDR_W | Sub-request address |
| sub_len | output | LEN_W | Sub-request beats minus one |
| sub_size | output | 3 | Sub-request size |
| sub_burst | output | 2 | Burst code, copied |
| sub_cache_mod | output | 1 | Cache modifiable bit, copied |
| sub_lock | output | 1 | Lock bit, copied |
| sub_last | output | 1 | Final piece of the request |
| size_irq | output | 1 | Pulse on a forced size change |
| bin_valid | input | 1 | Piece write response valid |
| bin_ready | output | 1 | Piece write response taken |
| bin_code | input | 2 | Piece response code |
| bout_valid | output | 1 | Merged response valid |
| bout_ready | input | 1 | Merged response taken |
| bout_code | output | 2 | Merged response code |

## Verification
The assertions check properties that hold on every cycle:
- sub-request fields hold under back-pressure;
- no non-exclusive INCR piece spans more than a 256-byte window;
- modifiable INCR pieces use size 4, and FIXED pieces never exceed size 4;
- the interrupt lasts a single cycle;
- merged responses hold and block new piece responses.

Only the bench scenarios can show the rest:
- the exact piece sequence for unaligned starts;
- the clamped interleave spans;
- the split between narrow, forced-up and downsized sizes;
- the exclusive special cases;
- that the merged code is the worst code of the right request.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int FAB_SIZE = 4;

  typedef enum logic [1:0] {
    BT_FIXED = 2'd0,
    BT_INCR  = 2'd1,
    BT_WRAP  = 2'd2,
    BT_RSVD  = 2'd3
  } burst_e;

  localparam logic [1:0] RC_OKAY = 2'd0;

  function automatic logic [1:0] worse_code(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/chop_decode.sv
module chop_decode
  import chop_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 8,
  parameter int DEF_CHOP_LG = 8,
  parameter int MIN_CHOP_LG = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [2:0]        size,
  input  logic [1:0]        burst,
  input  logic              cache_mod,
  input  logic              lock,
  input  logic              is_ddr,
  input  logic              ilv_en,
  input  logic [3:0]        ilv_lg,
  output logic [2:0]        out_size,
  output logic              irq,
  output logic [ADDR_W-1:0] last_addr,
  output logic [ADDR_W-1:0] chop_mask,
  output logic [LEN_W-1:0]  flat_len,
  output logic              split
);
  localparam logic [2:0] FAB = 3'(FAB_SIZE);

  logic              is_incr, is_fixed, mod_flow;
  logic [ADDR_W-1:0] base, span;
  logic [LEN_W+3:0]  ext;
  int                lg_i;

  always_comb begin
    is_incr  = (burst == BT_INCR);
    is_fixed = (burst == BT_FIXED);
    mod_flow = is_incr && (lock ? (is_ddr && (len != '0)) : cache_mod);

    if (!is_incr && !is_fixed)                          out_size = size;
    else if (mod_flow)                                  out_size = FAB;
    else if (size > FAB)                                out_size = FAB;
    else if (is_incr && is_ddr && !lock && size < FAB)  out_size = FAB;
    else                                                out_size = size;

    irq = (is_incr || is_fixed) && !mod_flow && (out_size != size);

    base      = addr & ({ADDR_W{1'b1}} << size);
    span      = ({{(ADDR_W-LEN_W){1'b0}}, len} + ADDR_W'(1)) << size;
    last_addr = base + span - ADDR_W'(1);

    lg_i = DEF_CHOP_LG;
    if (is_ddr && ilv_en) begin
      lg_i = int'(ilv_lg);
      if (lg_i < MIN_CHOP_LG) lg_i = MIN_CHOP_LG;
      if (lg_i > DEF_CHOP_LG) lg_i = DEF_CHOP_LG;
    end
    chop_mask = lock ? {ADDR_W{1'b1}} : ~({ADDR_W{1'b1}} << lg_i);

    if (is_fixed && size > FAB)
      ext = ({4'b0, len} + (LEN_W+4)'(1)) << (size - FAB);
    else
      ext = {4'b0, len} + (LEN_W+4)'(1);
    flat_len = LEN_W'(ext - (LEN_W+4)'(1));

    split = is_incr;
  end
endmodule

// File: rtl/piece_gen.sv
module piece_gen
  import chop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [ADDR_W-1:0] ld_last,
  input  logic [ADDR_W-1:0] ld_mask,
  input  logic [2:0]        ld_size,
  input  logic [LEN_W-1:0]  ld_flat_len,
  input  logic              ld_split,
  input  logic [1:0]        ld_burst,
  input  logic              ld_mod,
  input  logic              ld_lock,
  input  logic              ld_write,
  output logic              busy,
  output logic              sub_valid,
  input  logic              sub_ready,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [LEN_W-1:0]  sub_len,
  output logic [2:0]        sub_size,
  output logic [1:0]        sub_burst,
  output logic              sub_cache_mod,
  output logic              sub_lock,
  output logic              sub_last,
  output logic              push,
  output logic [CNT_W-1:0]  push_cnt
);
  logic [ADDR_W-1:0] cur_q, last_q, mask_q, bound, pend;
  logic [2:0]        size_q;
  logic [LEN_W-1:0]  flen_q;
  logic              split_q, mod_q, lock_q, wr_q;
  logic [1:0]        burst_q;
  logic [CNT_W-1:0]  pcnt_q;
  logic              fire;

  always_comb begin
    bound    = cur_q | mask_q;
    pend     = (split_q && (bound < last_q)) ? bound : last_q;
    sub_len  = split_q ? LEN_W'((pend >> size_q) - (cur_q >> size_q)) : flen_q;
    sub_last = !split_q || (pend == last_q);
  end

  assign sub_valid     = busy;
  assign sub_addr      = cur_q;
  assign sub_size      = size_q;
  assign sub_burst     = burst_q;
  assign sub_cache_mod = mod_q;
  assign sub_lock      = lock_q;
  assign fire          = busy && sub_ready;
  assign push          = fire && sub_last && wr_q;
  assign push_cnt      = pcnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_q   <= '0;
      last_q  <= '0;
      mask_q  <= '0;
      size_q  <= '0;
      flen_q  <= '0;
      split_q <= 1'b0;
      burst_q <= '0;
      mod_q   <= 1'b0;
      lock_q  <= 1'b0;
      wr_q    <= 1'b0;
      pcnt_q  <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      cur_q   <= ld_addr;
      last_q  <= ld_last;
      mask_q  <= ld_mask;
      size_q  <= ld_size;
      flen_q  <= ld_flat_len;
      split_q <= ld_split;
      burst_q <= ld_burst;
      mod_q   <= ld_mod;
      lock_q  <= ld_lock;
      wr_q    <= ld_write;
      pcnt_q  <= '0;
    end else if (fire) begin
      if (sub_last) begin
        busy <= 1'b0;
      end else begin
        cur_q  <= pend + ADDR_W'(1);
        pcnt_q <= pcnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/resp_merge.sv
module resp_merge
  import chop_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [CNT_W-1:0] push_cnt,
  output logic             full,
  input  logic             bin_valid,
  output logic             bin_ready,
  input  logic [1:0]       bin_code,
  output logic             bout_valid,
  input  logic             bout_ready,
  output logic [1:0]       bout_code
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = PTR_W + 1;

  logic [CNT_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0] occ;
  logic [CNT_W-1:0] rcv_q;
  logic [1:0]       worst_q;
  logic             have, complete, pop, take;

  assign have      = (occ != '0);
  assign full      = (occ == OCC_W'(DEPTH));
  assign complete  = have && (rcv_q == slots[rd_ptr]) && !bout_valid;
  assign bin_ready = !bout_valid && !complete;
  assign take      = bin_valid && bin_ready;
  assign pop       = complete;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)                              slots[i] <= '0;
        else if (push && wr_ptr == PTR_W'(i))    slots[i] <= push_cnt;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      occ        <= '0;
      rcv_q      <= '0;
      worst_q    <= RC_OKAY;
      bout_valid <= 1'b0;
      bout_code  <= RC_OKAY;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      occ <= occ + OCC_W'(push) - OCC_W'(pop);

      if (complete) begin
        bout_valid <= 1'b1;
        bout_code  <= worst_q;
        rcv_q      <= '0;
        worst_q    <= RC_OKAY;
      end else if (take) begin
        rcv_q   <= rcv_q + CNT_W'(1);
        worst_q <= worse_code(worst_q, bin_code);
      end

      if (bout_valid && bout_ready) bout_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/axi_burst_chopper.sv
module axi_burst_chopper
  import chop_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 8,
  parameter int DEF_CHOP_LG = 8,
  parameter int MIN_CHOP_LG = 4,
  parameter int TRK_DEPTH   = 4,
  parameter int CNT_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [2:0]        req_size,
  input  logic [1:0]        req_burst,
  input  logic              req_cache_mod,
  input  logic              req_lock,
  input  logic              req_ddr,
  input  logic              ilv_enable,
  input  logic [3:0]        ilv_gran_lg,
  output logic              sub_valid,
  input  logic              sub_ready,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [LEN_W-1:0]  sub_len,
  output logic [2:0]        sub_size,
  output logic [1:0]        sub_burst,
  output logic              sub_cache_mod,
  output logic              sub_lock,
  output logic              sub_last,
  output logic              size_irq,
  input  logic              bin_valid,
  output logic              bin_ready,
  input  logic [1:0]        bin_code,
  output logic              bout_valid,
  input  logic              bout_ready,
  output logic [1:0]        bout_code
);
  logic [2:0]        d_size;
  logic              d_irq, d_split;
  logic [ADDR_W-1:0] d_last, d_mask;
  logic [LEN_W-1:0]  d_flen;
  logic              busy, trk_full, accept, push;
  logic [CNT_W-1:0]  push_cnt;

  assign req_ready = !busy && !trk_full;
  assign accept    = req_valid && req_ready;

  chop_decode #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .DEF_CHOP_LG(DEF_CHOP_LG), .MIN_CHOP_LG(MIN_CHOP_LG)
  ) u_dec (
    .addr(req_addr), .len(req_len), .size(req_size), .burst(req_burst),
    .cache_mod(req_cache_mod), .lock(req_lock), .is_ddr(req_ddr),
    .ilv_en(ilv_enable), .ilv_lg(ilv_gran_lg),
    .out_size(d_size), .irq(d_irq), .last_addr(d_last), .chop_mask(d_mask),
    .flat_len(d_flen), .split(d_split)
  );

  piece_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .ld_addr(req_addr), .ld_last(d_last), .ld_mask(d_mask), .ld_size(d_size),
    .ld_flat_len(d_flen), .ld_split(d_split), .ld_burst(req_burst),
    .ld_mod(req_cache_mod), .ld_lock(req_lock), .ld_write(req_write),
    .busy(busy), .sub_valid(sub_valid), .sub_ready(sub_ready),
    .sub_addr(sub_addr), .sub_len(sub_len), .sub_size(sub_size),
    .sub_burst(sub_burst), .sub_cache_mod(sub_cache_mod), .sub_lock(sub_lock),
    .sub_last(sub_last), .push(push), .push_cnt(push_cnt)
  );

  resp_merge #(.DEPTH(TRK_DEPTH), .CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .push(push), .push_cnt(push_cnt), .full(trk_full),
    .bin_valid(bin_valid), .bin_ready(bin_ready), .bin_code(bin_code),
    .bout_valid(bout_valid), .bout_ready(bout_ready), .bout_code(bout_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) size_irq <= 1'b0;
    else        size_irq <= accept && d_irq;
  end
endmodule

// File: rtl/chopper_props.sv
module chopper_props #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 8,
  parameter int DEF_CHOP_LG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sub_valid,
  input logic              sub_ready,
  input logic [ADDR_W-1:0] sub_addr,
  input logic [LEN_W-1:0]  sub_len,
  input logic [2:0]        sub_size,
  input logic [1:0]        sub_burst,
  input logic              sub_cache_mod,
  input logic              sub_lock,
  input logic              size_irq,
  input logic              bin_ready,
  input logic              bout_valid,
  input logic              bout_ready,
  input logic [1:0]        bout_code
);
  logic [ADDR_W-1:0] end_byte;
  always_comb
    end_byte = (((sub_addr >> sub_size) + {{(ADDR_W-LEN_W){1'b0}}, sub_len} + ADDR_W'(1))
                << sub_size) - ADDR_W'(1);

  // R1
  sub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && !sub_ready |=> sub_valid && $stable(sub_addr) && $stable(sub_len)
                                && $stable(sub_size) && $stable(sub_burst));
  // R4
  no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && sub_burst == 2'd1 && !sub_lock |-> (end_byte >> DEF_CHOP_LG) == (sub_addr >> DEF_CHOP_LG));
  // R2
  mod_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && sub_burst == 2'd1 && sub_cache_mod && !sub_lock |-> sub_size == 3'd4);
  // R9
  fixed_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && sub_burst == 2'd0 |-> sub_size <= 3'd4);
  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_irq |=> !size_irq);
  // R12
  bout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bout_valid && !bout_ready |=> bout_valid && $stable(bout_code));
  // R12
  bin_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bout_valid |-> !bin_ready);
endmodule

bind axi_burst_chopper chopper_props #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEF_CHOP_LG(DEF_CHOP_LG)
) u_props (
  .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_ready(sub_ready),
  .sub_addr(sub_addr), .sub_len(sub_len), .sub_size(sub_size), .sub_burst(sub_burst),
  .sub_cache_mod(sub_cache_mod), .sub_lock(sub_lock), .size_irq(size_irq),
  .bin_ready(bin_ready), .bout_valid(bout_valid), .bout_ready(bout_ready),
  .bout_code(bout_code)
);

// File: tb/sim_axi_burst_chopper.sv
`timescale 1ns/1ps
module sim_axi_burst_chopper;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_ready, req_write = 0;
  logic [31:0] req_addr = 0;
  logic [7:0]  req_len = 0;
  logic [2:0]  req_size = 0;
  logic [1:0]  req_burst = 0;
  logic        req_cache_mod = 0, req_lock = 0, req_ddr = 0, ilv_enable = 0;
  logic [3:0]  ilv_gran_lg = 0;
  logic        sub_valid, sub_ready = 0, sub_cache_mod, sub_lock, sub_last, size_irq;
  logic [31:0] sub_addr;
  logic [7:0]  sub_len;
  logic [2:0]  sub_size;
  logic [1:0]  sub_burst;
  logic        bin_valid = 0, bin_ready, bout_valid, bout_ready = 0;
  logic [1:0]  bin_code = 0, bout_code;

  axi_burst_chopper u0 (.*);

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0, irq_exp = 0;
  longint q_addr[$]; int q_len[$], q_size[$], q_last[$], q_wr[$], q_code[$], q_meta[$];
  string q_tag[$];
  int q_irq[$], q_b[$], pend[$];

  task automatic chk(input bit ok, input string msg);
    n_cmp++;
    if (!ok) begin n_bad++; $display("FAIL %s", msg); end
  endtask

  // Behavioural expectation built from the requirements
  task automatic model(input string tag, input longint a, input int l, input int s, input int b,
                       input bit m, input bit lk, input bit d, input bit en, input int lg,
                       input bit w, input int ep, input int ec);
    bit incr, fixd, mf, irq; int os, worst, idx, cd, g, nl; longint e, c, p, pe;
    incr = (b == 1); fixd = (b == 0); worst = 0; idx = 0;
    mf = incr && (lk ? (d && l != 0) : m);
    if (!incr && !fixd) os = s;
    else if (mf) os = 4;
    else if (s > 4) os = 4;
    else if (incr && d && !lk && s < 4) os = 4;
    else os = s;
    irq = (incr || fixd) && !mf && (os != s);
    q_irq.push_back(irq);
    if (!incr) begin
      nl = (fixd && s > 4) ? (((l + 1) << (s - 4)) - 1) : l;
      cd = (ep == 0) ? ec : 0; worst = cd;
      q_addr.push_back(a); q_len.push_back(nl); q_size.push_back(os); q_last.push_back(1);
      q_wr.push_back(w); q_code.push_back(cd); q_meta.push_back(b*4 + m*2 + lk); q_tag.push_back(tag);
    end else begin
      e = ((a >> s) << s) + (longint'(l + 1) << s) - 1;
      if (lk) c = 64'h1_0000_0000_0;
      else if (d && en) begin g = (lg < 4) ? 4 : (lg > 8 ? 8 : lg); c = 64'd1 << g; end
      else c = 256;
      p = a;
      forever begin
        pe = ((p / c) + 1) * c - 1;
        if (pe > e) pe = e;
        cd = (idx == ep) ? ec : 0;
        if (cd > worst) worst = cd;
        q_addr.push_back(p); q_len.push_back(int'((pe >> os) - (p >> os))); q_size.push_back(os);
        q_last.push_back(pe == e); q_wr.push_back(w); q_code.push_back(cd);
        q_meta.push_back(b*4 + m*2 + lk); q_tag.push_back(tag);
        idx++;
        if (pe == e) break;
        p = pe + 1;
      end
    end
    if (w) q_b.push_back(worst);
  endtask

  task automatic issue(input string tag, input longint a, input int l, input int s, input int b,
                       input bit m, input bit lk, input bit d, input bit en, input int lg,
                       input bit w, input int ep, input int ec);
    model(tag, a, l, s, b, m, lk, d, en, lg, w, ep, ec);
    @(posedge clk); #1;
    req_addr = a[31:0]; req_len = 8'(l); req_size = 3'(s); req_burst = 2'(b);
    req_cache_mod = m; req_lock = lk; req_ddr = d; ilv_enable = en; ilv_gran_lg = 4'(lg);
    req_write = w; req_valid = 1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1 req_valid = 0;
  endtask

  // Stimulus-side ready/valid drivers, updated just after each edge
  always @(posedge clk) begin
    #1;
    sub_ready  = (cyc % 5) != 3;
    bout_ready = (cyc % 7) != 2;
    bin_valid  = (pend.size() > 0);
    bin_code   = (pend.size() > 0) ? 2'(pend[0]) : 2'd0;
  end

  // Reference comparison every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      chk(size_irq == irq_exp, $sformatf("R7 R6 R9 irq act=%0d exp=%0d", size_irq, irq_exp));
      irq_exp = 0;
      if (req_valid && req_ready) irq_exp = (q_irq.size() > 0) ? q_irq.pop_front() : 0;
      if (sub_valid) begin
        chk(!req_ready, $sformatf("R1 req_ready act=%0d exp=0 while piece pending", req_ready));
        if (q_addr.size() == 0) chk(0, $sformatf("R1 unexpected piece addr=%h exp none", sub_addr));
        else begin
          chk(sub_addr == q_addr[0][31:0] && sub_len == q_len[0] && sub_size == q_size[0] &&
              sub_last == q_last[0] && {sub_burst, sub_cache_mod, sub_lock} == q_meta[0],
              $sformatf("%s piece act a=%h l=%0d s=%0d last=%0d meta=%0d exp a=%h l=%0d s=%0d last=%0d meta=%0d",
                        q_tag[0], sub_addr, sub_len, sub_size, sub_last, {sub_burst, sub_cache_mod, sub_lock},
                        q_addr[0], q_len[0], q_size[0], q_last[0], q_meta[0]));
          if (sub_ready) begin
            if (q_wr[0]) pend.push_back(q_code[0]);
            void'(q_addr.pop_front()); void'(q_len.pop_front()); void'(q_size.pop_front());
            void'(q_last.pop_front()); void'(q_wr.pop_front()); void'(q_code.pop_front());
            void'(q_meta.pop_front()); void'(q_tag.pop_front());
          end
        end
      end
      if (bin_valid && bin_ready) void'(pend.pop_front());
      if (bout_valid) begin
        if (q_b.size() == 0) chk(0, $sformatf("R11 merged act=%0d exp none", bout_code));
        else begin
          chk(bout_code == q_b[0], $sformatf("R11 R12 merged act=%0d exp=%0d", bout_code, q_b[0]));
          if (bout_ready) void'(q_b.pop_front());
        end
      end
      if (cyc > 100000) begin
        chk(0, "R1 watchdog act=hung exp=finish");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk(req_ready && !sub_valid && !bout_valid && !size_irq,
        $sformatf("R13 reset act rdy=%0d sv=%0d bv=%0d irq=%0d exp 1 0 0 0",
                  req_ready, sub_valid, bout_valid, size_irq));
    issue("R2 R4",  32'h1000, 255, 2, 1, 1, 0, 0, 0, 0, 0, -1, 0);
    issue("R2 R4",  32'h10F0,  31, 4, 1, 1, 0, 0, 0, 0, 1, -1, 0);
    issue("R3 R11", 32'h4000,  15, 4, 1, 1, 0, 1, 1, 6, 1,  1, 2);
    issue("R3",     32'h5080,  15, 4, 1, 1, 0, 1, 0, 6, 0, -1, 0);
    issue("R3",     32'h6000,  63, 4, 1, 1, 0, 1, 1, 12, 0, -1, 0);
    issue("R3",     32'h7000,   3, 4, 1, 1, 0, 1, 1, 2, 1, -1, 0);
    issue("R5 R4",  32'h2000, 200, 1, 1, 0, 0, 0, 0, 0, 0, -1, 0);
    issue("R6",     32'h8000,   7, 2, 1, 0, 0, 1, 0, 0, 1, -1, 0);
    issue("R7",     32'h9000,   7, 6, 1, 0, 0, 0, 0, 0, 1,  0, 3);
    issue("R8",     32'hA000,  15, 5, 1, 1, 1, 0, 0, 0, 1,  0, 1);
    issue("R8",     32'hB004,   0, 2, 1, 1, 1, 1, 1, 6, 0, -1, 0);
    issue("R8",     32'hB004,   3, 2, 1, 0, 1, 1, 1, 4, 1,  0, 1);
    issue("R8",     32'hB100,   3, 2, 1, 1, 1, 0, 0, 0, 0, -1, 0);
    issue("R9",     32'hC00C,  15, 2, 0, 1, 0, 0, 0, 0, 0, -1, 0);
    issue("R9",     32'hC040,   3, 6, 0, 0, 0, 1, 0, 0, 1,  0, 2);
    issue("R10",    32'hD004,   7, 3, 2, 1, 0, 0, 0, 0, 0, -1, 0);
    issue("R10",    32'hD104,   2, 1, 3, 0, 0, 1, 0, 0, 1, -1, 0);
    issue("R11",    32'hE000,  63, 4, 1, 1, 0, 0, 0, 0, 1,  3, 3);
    for (int i = 0; i < 6; i++)
      issue("R11 R12", 32'hF000 + i * 32'h48, 20 + i, 3, 1, 1, 0, i % 2, 1, 5, 1, i % 3, i % 4);
    for (int i = 0; i < 3000 && (q_addr.size() + q_b.size() + pend.size()) != 0; i++)
      @(negedge clk);
    @(negedge clk);
    chk(q_addr.size() == 0 && q_b.size() == 0,
        $sformatf("R11 drain act pieces=%0d merged=%0d exp 0 0", q_addr.size(), q_b.size()));
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule